// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Per-Set Recency Bit

This block is a 4 KB read cache of one-word (4-byte) lines, organised as 512 sets of two ways. The word address of a request picks a set. Both ways of that set are examined in the same cycle, and a way that is valid and holds the matching tag returns its word at once. When neither way matches, a small controller fetches the aligned word from the next memory level, writes it into one way of the set, and then serves the request that is still waiting. Two addresses with the same set number but different tags can therefore be resident together. A direct-mapped layout would instead make them evict each other.

The requester holds `cpu_req` and `cpu_addr` steady until `cpu_ready` rises. The controller has three named states. LOOKUP is the idle and hit state. FETCH keeps `mem_req` asserted until `mem_ack`. FILL writes the returned word in one cycle. The transitions are: LOOKUP to FETCH on a request that misses, FETCH to FILL on acknowledge, FILL to LOOKUP unconditionally, and LOOKUP to LOOKUP on a hit or when there is no request. Each set keeps one recency bit that names the way to evict next. With two ways, this bit is both the least-recently-used choice and the not-most-recently-used choice.

Top module: `cache2w_top`

## Requirements
- R1: After reset every frame is invalid, `cpu_ready` and `mem_req` are low, and the first request to any address misses.
- R2: Address bits [10:2] select the set and bits [31:11] form the 21-bit tag. Bits [1:0] do not affect hit or miss, so addresses that differ only in those bits hit the same line.
- R3: A request whose tag matches a valid way in its set raises `cpu_ready` in the same cycle it is presented, and `cpu_rdata` carries that way's word. At most one way hits.
- R4: On a miss, `cpu_ready` stays low and the controller enters FETCH on the next clock. In FETCH it holds `mem_req` high with a stable `mem_addr` equal to the request address with bits [1:0] cleared, until `mem_ack` is seen. Exactly one transfer takes place per miss and none per hit.
- R5: The clock edge that sees `mem_req` and `mem_ack` together moves the controller to FILL. FILL lasts one cycle and writes the word. In the following LOOKUP cycle the held request hits and returns the fetched word. Between request and `cpu_ready`, a miss therefore takes (acknowledge wait cycles) + 2 cycles.
- R6: The fill goes into an invalid way of the set when one exists, way 0 before way 1. Only when both ways are valid does it go into the way named by the set's recency bit.
- R7: Every hit and every fill sets the recency bit of its set to the way that was not touched.
- R8: Two addresses with the same set number and different tags stay resident together, and both hit until a third tag in that set evicts one of them.
- R9: In LOOKUP with `cpu_req` low, the controller issues no memory request and changes neither the valid bits nor the recency bits, whatever `cpu_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Read request, held until `cpu_ready` |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_ready | output | 1 | Request served this cycle |
| cpu_rdata | output | 32 | Word read, valid with `cpu_ready` |
| mem_req | output | 1 | Fetch request to the next level |
| mem_addr | output | 32 | Word-aligned fetch address |
| mem_ack | input | 1 | Next level returns `mem_rdata` this cycle |
| mem_rdata | input | 32 | Fetched word |

## Verification
The hardest case to reach from the ports is eviction by recency. It needs a set whose two ways are both valid, the right way touched last, and then a third tag in the same set. The order of the following hits and misses is the only thing that shows which way left. Directed sequences build this state deliberately. One of them leaves `cpu_addr` on a resident line with `cpu_req` low before the conflict, to show that an idle address does not disturb the recency bit. A long pseudo-random phase then concentrates requests on four sets with eight tags each, including the top and bottom tag values. A behavioural model predicts, cycle by cycle, the hit or miss, the memory handshake and the returned word.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_FETCH  = 2'd1,
        ST_FILL   = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int SETS   = 512,
    parameter int TAG_W  = 21,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] word_q [SETS];

    // Valid bits are the only per-frame state that needs a reset value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            word_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        valid_o = valid_q[rd_idx];
        hit_o   = valid_o && (tag_q[rd_idx] == rd_tag);
        data_o  = word_q[rd_idx];
    end
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
    parameter int SETS  = 512,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             evict_way_o,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);
    // One bit per set naming the way to evict next.
    logic [SETS-1:0] recency_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recency_q <= '0;
        end else if (upd_en) begin
            recency_q[upd_idx] <= ~upd_way;
        end
    end

    assign evict_way_o = recency_q[rd_idx];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFFS_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              hit_any,
    input  logic              victim_way,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fill_en,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              fill_way,
    output logic [DATA_W-1:0] fill_data
);
    ctl_state_e        state_q, state_d;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              victim_q;
    logic [DATA_W-1:0] fetched_q;
    logic              lookup_miss;

    assign lookup_miss = (state_q == ST_LOOKUP) && cpu_req && !hit_any;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: if (cpu_req && !hit_any) state_d = ST_FETCH;
            ST_FETCH:  if (mem_ack)             state_d = ST_FILL;
            ST_FILL:                            state_d = ST_LOOKUP;
            default:                            state_d = ST_LOOKUP;
        endcase
    end

    // Miss context: captured when the miss is detected, word when acknowledged.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_addr_q <= '0;
            victim_q    <= 1'b0;
            fetched_q   <= '0;
        end else begin
            if (lookup_miss) begin
                miss_addr_q <= {cpu_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
                victim_q    <= victim_way;
            end
            if ((state_q == ST_FETCH) && mem_ack) begin
                fetched_q <= mem_rdata;
            end
        end
    end

    // Outputs.
    always_comb begin
        cpu_ready = (state_q == ST_LOOKUP) && cpu_req && hit_any;
        mem_req   = (state_q == ST_FETCH);
        mem_addr  = miss_addr_q;
        fill_en   = (state_q == ST_FILL);
        fill_addr = miss_addr_q;
        fill_way  = victim_q;
        fill_data = fetched_q;
    end

    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4

    AST_MISS_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !hit_any) |-> !cpu_ready); // R4

    AST_ACK_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (fill_en && !mem_req)); // R5

    AST_FILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (!fill_en && !mem_req)); // R5

    AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && !mem_req && !fill_en) |=> !mem_req); // R9
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int SETS        = 512,
    parameter int BLOCK_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFFS_W = $clog2(BLOCK_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;

    logic [IDX_W-1:0]  rd_idx;
    logic [TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]   hit_vec;
    logic [WAYS-1:0]   valid_vec;
    logic [DATA_W-1:0] way_data [WAYS];
    logic              hit_any;
    logic              evict_way;
    logic              victim_way;

    logic              fill_en;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_way;
    logic [DATA_W-1:0] fill_data;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;

    logic              upd_en;
    logic [IDX_W-1:0]  upd_idx;
    logic              upd_way;

    assign rd_idx   = cpu_addr[OFFS_W +: IDX_W];
    assign rd_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign fill_idx = fill_addr[OFFS_W +: IDX_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

    // Both ways are read in parallel.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache2w_way #(
            .SETS   (SETS),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W)
        ) way_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (rd_idx),
            .rd_tag  (rd_tag),
            .wr_en   (fill_en && (fill_way == w[0])),
            .wr_idx  (fill_idx),
            .wr_tag  (fill_tag),
            .wr_data (fill_data),
            .hit_o   (hit_vec[w]),
            .valid_o (valid_vec[w]),
            .data_o  (way_data[w])
        );
    end

    assign hit_any   = |hit_vec;
    assign cpu_rdata = hit_vec[1] ? way_data[1] : way_data[0];

    // Victim: an empty way first, lower way first; otherwise the recency bit.
    always_comb begin
        if (!valid_vec[0]) begin
            victim_way = 1'b0;
        end else if (!valid_vec[1]) begin
            victim_way = 1'b1;
        end else begin
            victim_way = evict_way;
        end
    end

    // Recency update on a served hit or on a fill.
    always_comb begin
        upd_en  = cpu_ready || fill_en;
        upd_idx = fill_en ? fill_idx : rd_idx;
        upd_way = fill_en ? fill_way : hit_vec[1];
    end

    cache2w_lru #(
        .SETS  (SETS),
        .IDX_W (IDX_W)
    ) lru_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (rd_idx),
        .evict_way_o (evict_way),
        .upd_en      (upd_en),
        .upd_idx     (upd_idx),
        .upd_way     (upd_way)
    );

    cache2w_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFFS_W (OFFS_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_addr   (cpu_addr),
        .hit_any    (hit_any),
        .victim_way (victim_way),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .cpu_ready  (cpu_ready),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fill_en    (fill_en),
        .fill_addr  (fill_addr),
        .fill_way   (fill_way),
        .fill_data  (fill_data)
    );

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3

    AST_READY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (hit_vec != '0)); // R3

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFFS_W-1:0] == '0)); // R4
endmodule

// File: tb/cache2w_tb.sv
module cache2w_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int tests = 0;
    int failed = 0;
    int xfers = 0;
    logic [31:0] last_mem_addr = '0;

    // Behavioural reference: valid, tag and recency per set and way.
    bit          m_valid [2][512];
    logic [20:0] m_tag   [2][512];
    bit          m_evict [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    cache2w_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
    endfunction

    function automatic bit model_access(input logic [31:0] a);
        int          s = int'(a[10:2]);
        logic [20:0] t = a[31:11];
        int          v;
        for (int w = 0; w < 2; w++) begin
            if (m_valid[w][s] && m_tag[w][s] == t) begin
                m_evict[s] = (w == 0);
                return 1'b1;
            end
        end
        if (!m_valid[0][s])      v = 0;
        else if (!m_valid[1][s]) v = 1;
        else                     v = m_evict[s] ? 1 : 0;
        m_valid[v][s] = 1'b1;
        m_tag[v][s]   = t;
        m_evict[s]    = (v == 0);
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Next-level memory: acknowledges after MEM_LAT cycles of request.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                cnt++;
                if (cnt == MEM_LAT) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                    xfers++;
                    last_mem_addr = mem_addr;
                end
            end
        end
    end

    task automatic do_access(input logic [31:0] a);
        bit          exp_hit = model_access(a);
        int          exp_cyc = exp_hit ? 0 : MEM_LAT + 2;
        int          x0 = xfers;
        bit          cyc_ok = 1'b1;
        int          bad_k = 0;
        logic [31:0] aligned = {a[31:2], 2'b00};
        @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = a;
        for (int k = 0; k <= exp_cyc; k++) begin
            bit exp_mreq;
            if (k > 0) @(negedge clk);
            #1;
            exp_mreq = !exp_hit && (k >= 1) && (k <= MEM_LAT);
            if (cyc_ok && (cpu_ready !== (k == exp_cyc) || mem_req !== exp_mreq)) begin
                cyc_ok = 1'b0;
                bad_k  = k;
            end
        end
        if (exp_hit)
            check(cyc_ok, "R3", "hit timing (fail cycle)", bad_k, 0);
        else
            check(cyc_ok, "R5", "miss timing (fail cycle)", bad_k, exp_cyc);
        check(cpu_rdata === mem_word(aligned), exp_hit ? "R3" : "R5",
              "read data", cpu_rdata, mem_word(aligned));
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        check(xfers - x0 == (exp_hit ? 0 : 1), "R4", "transfers",
              xfers - x0, exp_hit ? 0 : 1);
        if (!exp_hit)
            check(last_mem_addr === aligned, "R4", "fetch address",
                  last_mem_addr, aligned);
    endtask

    function automatic logic [31:0] mk(input logic [20:0] t, input int s,
                                       input logic [1:0] off);
        return {t, s[8:0], off};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failed++;
        $display("FAIL watchdog act=%0d exp=<%0d cycles", WATCHDOG, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'hC0DE_1234;
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 512; s++) begin
                m_valid[w][s] = 1'b0;
                m_tag[w][s]   = '0;
            end
        for (int s = 0; s < 512; s++) m_evict[s] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: quiet outputs after reset
        check(cpu_ready === 1'b0, "R1", "ready after reset", cpu_ready, 0);
        check(mem_req === 1'b0, "R1", "mem_req after reset", mem_req, 0);

        // R1: first access misses; R3: repeat hits
        do_access(mk(21'h0, 5, 2'b00));
        do_access(mk(21'h0, 5, 2'b00));
        // R2: other byte offsets of the same word hit
        do_access(mk(21'h0, 5, 2'b11));
        // R2/R6/R8: tag differs only in bit 11, fills second way, both stay
        do_access(mk(21'h1, 5, 2'b00));
        do_access(mk(21'h0, 5, 2'b01));
        do_access(mk(21'h1, 5, 2'b10));
        do_access(mk(21'h0, 5, 2'b00));

        // R9: idle with a resident address presented must not touch recency
        @(negedge clk);
        cpu_addr = mk(21'h1, 5, 2'b00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            check(cpu_ready === 1'b0 && mem_req === 1'b0, "R9", "idle outputs",
                  {cpu_ready, mem_req}, 0);
        end
        // R6/R7: third tag evicts the least recently touched way
        do_access(mk(21'h2, 5, 2'b00));
        do_access(mk(21'h0, 5, 2'b00));
        do_access(mk(21'h1, 5, 2'b00));
        do_access(mk(21'h2, 5, 2'b00));

        // R2: boundary sets and extreme tags
        do_access(mk(21'h1F_FFFF, 511, 2'b00));
        do_access(mk(21'h10_0000, 511, 2'b00));
        do_access(mk(21'h0, 0, 2'b00));
        do_access(mk(21'h1F_FFFF, 511, 2'b10));
        do_access(mk(21'h0, 511, 2'b00));
        do_access(mk(21'h10_0000, 511, 2'b01));

        // R6/R7/R8: concentrated pseudo-random conflict traffic
        for (int n = 0; n < 250; n++) begin
            int          s;
            logic [20:0] t;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[1:0])
                2'd0: s = 3;
                2'd1: s = 7;
                2'd2: s = 300;
                default: s = 511;
            endcase
            case (lfsr[4:2])
                3'd4: t = 21'h10_0000;
                3'd5: t = 21'h1F_FFFF;
                default: t = {18'b0, lfsr[4:2]};
            endcase
            do_access(mk(t, s, lfsr[6:5]));
        end

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule